// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block gathers seven interrupt sources into one active-high interrupt request. Each source owns one sticky flag bit. A pulse on its set input raises the flag. The flag drops when another block drives the matching clear input, or when software writes a 1 to that bit of the flag register. A separate seven-bit mask decides which raised flags may reach the request line. Software changes the mask with a set/clear convention: the top data bit of the write chooses the direction, and the low seven bits choose which mask bits change.

Both registers sit on a byte-wide register bus with a chip select, a write strobe and a small address. Writes take effect at the rising clock edge. Reads are combinational. Bit 7 of the flag register is not stored. It is a summary that is 1 whenever some raised flag is also enabled. The request output follows that summary bit within the same cycle as any flag or mask change.

Each flag bit behaves as a two-state machine. In state Clear, the transition Raise (set input high) goes to state Pending. In state Pending, the transition Drop (clear input or bus clear, with the set input low) goes back to state Clear. If Raise and Drop occur together, the bit ends in Pending.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset all flag bits are 0 and the mask holds only the CB1 source (bit 4). A flag read returns 0x00, a mask read returns 0x90, and `irq` is 0.
- R2: A 1 on `src_set[i]` at a rising edge makes flag bit i equal to 1 after that edge. The bit then stays 1 until something clears it.
- R3: A selected write to the flag address clears every flag bit 6:0 whose data bit is 1. It leaves the bits written as 0 unchanged. Data bit 7 has no effect.
- R4: A 1 on `src_clr[i]` at a rising edge clears flag bit i.
- R5: When a set and a clear (from a clear input or a bus write) hit the same flag bit in one cycle, the bit ends up 1.
- R6: A selected write to the mask address with data bit 7 = 1 sets each mask bit 6:0 whose data bit is 1. The other mask bits stay unchanged.
- R7: A selected write to the mask address with data bit 7 = 0 clears each mask bit 6:0 whose data bit is 1. The other mask bits stay unchanged.
- R8: A mask read returns bit 7 as 1, with mask bits 6:0 in bits 6:0.
- R9: A flag read returns flag bits 6:0 in bits 6:0. Bit 7 is 1 exactly when (flags AND mask) in bits 6:0 is nonzero. This value reflects a flag or mask change in the same cycle the change is registered.
- R10: `irq` is high exactly when flag-read bit 7 would be 1.
- R11: The flag bit positions are: 0 CA2, 1 CA1, 2 shift register, 3 CB2, 4 CB1, 5 timer 2, 6 timer 1. Flag bit i is set by `src_set[i]`.
- R12: A write with `reg_sel` low, or a write to any address other than the flag address (2) and the mask address (3), changes no state. A read with `reg_sel` low or at another address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register bus select |
| reg_wr | input | 1 | Write strobe, valid with `reg_sel` |
| reg_addr | input | 4 | Register address: 2 = flags, 3 = mask |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data |
| src_set | input | 7 | Per-source flag set pulses |
| src_clr | input | 7 | Per-source flag clear pulses from other blocks |
| irq | output | 1 | Active-high interrupt request |

## Verification
A flag bit stuck in the wrong state, or a mask bit flipped, shows up on the next flag or mask read. It appears in the data bits right after the edge that registered it, and in `irq` whenever that bit is also enabled. A priority mistake between set and clear leaves a missing bit at the first read after the colliding cycle. A lost or crossed source position shows up as the wrong bit in the flag read taken one cycle after a single set pulse.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum int {
        SRC_CA2   = 0,
        SRC_CA1   = 1,
        SRC_SHIFT = 2,
        SRC_CB2   = 3,
        SRC_CB1   = 4,
        SRC_TMR2  = 5,
        SRC_TMR1  = 6
    } src_pos_e;

    localparam int SRC_COUNT = 7;

    function automatic logic [SRC_COUNT-1:0] default_mask();
        logic [SRC_COUNT-1:0] m;
        m = '0;
        m[SRC_CB1] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
    parameter int NSRC = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] hw_clr_i,
    input  logic            bus_clr_stb_i,
    input  logic [NSRC-1:0] bus_clr_mask_i,
    output logic [NSRC-1:0] flag_o
);

    logic [NSRC-1:0] drop;

    always_comb begin
        drop = hw_clr_i | (bus_clr_mask_i & {NSRC{bus_clr_stb_i}});
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_o[i] <= 1'b0;
            end else if (set_i[i]) begin
                flag_o[i] <= 1'b1;
            end else if (drop[i]) begin
                flag_o[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irqc_enable_reg.sv
module irqc_enable_reg #(
    parameter int              NSRC      = 7,
    parameter logic [NSRC-1:0] RST_VALUE = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_stb_i,
    input  logic            set_mode_i,
    input  logic [NSRC-1:0] sel_bits_i,
    output logic [NSRC-1:0] mask_o
);

    logic [NSRC-1:0] mask_next;

    always_comb begin
        mask_next = mask_o;
        if (wr_stb_i) begin
            if (set_mode_i) begin
                mask_next = mask_o | sel_bits_i;
            end else begin
                mask_next = mask_o & ~sel_bits_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o <= RST_VALUE;
        end else begin
            mask_o <= mask_next;
        end
    end

endmodule

// File: rtl/irqc_read_mux.sv
module irqc_read_mux #(
    parameter int                DATA_W    = 8,
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 2,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 3
) (
    input  logic              sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-2:0] flag_i,
    input  logic [DATA_W-2:0] mask_i,
    input  logic              summary_i,
    output logic [DATA_W-1:0] rdata_o
);

    always_comb begin
        rdata_o = '0;
        if (sel_i) begin
            if (addr_i == FLAG_ADDR) begin
                rdata_o = {summary_i, flag_i};
            end else if (addr_i == MASK_ADDR) begin
                rdata_o = {1'b1, mask_i};
            end
        end
    end

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
    parameter int                DATA_W    = 8,
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 2,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-2:0] src_set,
    input  logic [DATA_W-2:0] src_clr,
    output logic              irq
);

    localparam int NSRC = DATA_W - 1;
    localparam logic [NSRC-1:0] MASK_RST = NSRC'(irqc_pkg::default_mask());

    logic            wr_flag;
    logic            wr_mask;
    logic [NSRC-1:0] flag_q;
    logic [NSRC-1:0] en_q;
    logic            summary;

    always_comb begin
        wr_flag = reg_sel && reg_wr && (reg_addr == FLAG_ADDR);
        wr_mask = reg_sel && reg_wr && (reg_addr == MASK_ADDR);
    end

    irqc_flag_bank #(
        .NSRC (NSRC)
    ) u_flags (
        .clk            (clk),
        .rst_n          (rst_n),
        .set_i          (src_set),
        .hw_clr_i       (src_clr),
        .bus_clr_stb_i  (wr_flag),
        .bus_clr_mask_i (reg_wdata[NSRC-1:0]),
        .flag_o         (flag_q)
    );

    irqc_enable_reg #(
        .NSRC      (NSRC),
        .RST_VALUE (MASK_RST)
    ) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb_i   (wr_mask),
        .set_mode_i (reg_wdata[DATA_W-1]),
        .sel_bits_i (reg_wdata[NSRC-1:0]),
        .mask_o     (en_q)
    );

    always_comb begin
        summary = |(flag_q & en_q);
        irq     = summary;
    end

    irqc_read_mux #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .FLAG_ADDR (FLAG_ADDR),
        .MASK_ADDR (MASK_ADDR)
    ) u_rd (
        .sel_i     (reg_sel),
        .addr_i    (reg_addr),
        .flag_i    (flag_q),
        .mask_i    (en_q),
        .summary_i (summary),
        .rdata_o   (reg_rdata)
    );

endmodule

// File: rtl/irq_flag_ctrl_checker.sv
module irq_flag_ctrl_checker #(
    parameter int                DATA_W    = 8,
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 2,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_sel,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [DATA_W-2:0] src_set,
    input logic [DATA_W-2:0] src_clr,
    input logic              irq,
    input logic [DATA_W-2:0] flag_q,
    input logic [DATA_W-2:0] en_q
);

    localparam int NSRC = DATA_W - 1;

    // R2 and R5: a set always lands
    p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set != '0) |=> ((flag_q & $past(src_set)) == $past(src_set)));

    // R4
    p_hw_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_clr != '0) |=> ((flag_q & $past(src_clr & ~src_set)) == '0));

    // R3
    p_bus_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && reg_addr == FLAG_ADDR)
        |=> ((flag_q & $past(reg_wdata[NSRC-1:0] & ~src_set)) == '0));

    // R6
    p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && reg_addr == MASK_ADDR && reg_wdata[DATA_W-1])
        |=> ((en_q & $past(reg_wdata[NSRC-1:0])) == $past(reg_wdata[NSRC-1:0])));

    // R7
    p_mask_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && reg_addr == MASK_ADDR && !reg_wdata[DATA_W-1])
        |=> ((en_q & $past(reg_wdata[NSRC-1:0])) == '0));

    // R8
    p_mask_msb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_addr == MASK_ADDR) |-> reg_rdata[DATA_W-1]);

    // R10
    p_irq_matches_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_addr == FLAG_ADDR) |-> (reg_rdata[DATA_W-1] == irq));

    // R12
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!(reg_sel && reg_wr) && src_set == '0 && src_clr == '0)
        |=> ($stable(flag_q) && $stable(en_q)));

endmodule

bind irq_flag_ctrl irq_flag_ctrl_checker #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .FLAG_ADDR (FLAG_ADDR),
    .MASK_ADDR (MASK_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .src_set   (src_set),
    .src_clr   (src_clr),
    .irq       (irq),
    .flag_q    (flag_q),
    .en_q      (en_q)
);

// File: tb/irq_flag_ctrl_test.sv
`timescale 1ns/1ps
module irq_flag_ctrl_test;

    localparam int         PERIOD = 20;
    localparam logic [3:0] FA = 4'd2;
    localparam logic [3:0] MA = 4'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       reg_sel = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [6:0] src_set = '0;
    logic [6:0] src_clr = '0;
    logic       irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    bit chk_stb = 1'b0;

    logic [6:0] m_flag = '0;
    logic [6:0] m_en = 7'h10;

    logic [7:0] q_data[$];
    logic       q_irq[$];
    string      q_req[$];

    always #(PERIOD/2) clk = ~clk;

    irq_flag_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .src_set   (src_set),
        .src_clr   (src_clr),
        .irq       (irq)
    );

    // One clocked cycle of stimulus; reference model follows the requirements
    task automatic drive(input logic [6:0] s, input logic [6:0] c, input bit sel,
                         input bit wr, input logic [3:0] a, input logic [7:0] d);
        logic [6:0] drop;
        @(negedge clk);
        src_set = s; src_clr = c; reg_sel = sel; reg_wr = wr;
        reg_addr = a; reg_wdata = d;
        drop = c | ((sel && wr && a == FA) ? d[6:0] : 7'h00);
        m_flag = s | (m_flag & ~drop);
        if (sel && wr && a == MA)
            m_en = d[7] ? (m_en | d[6:0]) : (m_en & ~d[6:0]);
        @(negedge clk);
        src_set = '0; src_clr = '0; reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        drive('0, '0, 1'b1, 1'b1, a, d);
    endtask

    task automatic expect_rd(input logic [3:0] a, input string req);
        logic [7:0] e;
        @(negedge clk);
        if (a == FA)      e = {|(m_flag & m_en), m_flag};
        else if (a == MA) e = {1'b1, m_en};
        else              e = 8'h00;
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
        q_data.push_back(e);
        q_irq.push_back(|(m_flag & m_en));
        q_req.push_back(req);
        chk_stb = 1'b1;
        @(negedge clk);
        chk_stb = 1'b0; reg_sel = 1'b0;
    endtask

    // Monitor: pops expected items and compares after outputs settle
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (chk_stb && q_data.size() > 0) begin
                logic [7:0] ed;
                logic       ei;
                string      r;
                ed = q_data.pop_front();
                ei = q_irq.pop_front();
                r  = q_req.pop_front();
                checks++;
                if (reg_rdata !== ed || irq !== ei) begin
                    fails++;
                    $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                             r, reg_rdata, irq, ed, ei);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired (all requirements)");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        expect_rd(FA, "R1 flags after reset");
        expect_rd(MA, "R1 mask after reset");

        // R2, R9, R10: CB1 raises request
        drive(7'h10, '0, 1'b0, 1'b0, FA, '0);
        expect_rd(FA, "R2 R9 R10 CB1 set");
        drive(7'h40, '0, 1'b0, 1'b0, FA, '0);
        expect_rd(FA, "R2 timer1 set, still sticky CB1");

        // R3: bus clear, bit 7 of data ignored
        wr_reg(FA, 8'h90);
        expect_rd(FA, "R3 clear CB1 by write");
        wr_reg(FA, 8'h00);
        expect_rd(FA, "R3 zero write keeps flags");

        // R6, R8, R9: enable timer1
        wr_reg(MA, 8'hC0);
        expect_rd(MA, "R6 R8 mask set");
        expect_rd(FA, "R9 summary after mask set");

        // R7: clear timer1 enable
        wr_reg(MA, 8'h40);
        expect_rd(MA, "R7 mask clear");
        expect_rd(FA, "R7 R10 request drops");
        wr_reg(MA, 8'h80);
        expect_rd(MA, "R6 empty set write keeps mask");

        // R4: hardware clear
        drive('0, 7'h40, 1'b0, 1'b0, FA, '0);
        expect_rd(FA, "R4 hw clear timer1");

        // R5: set beats bus clear and hw clear
        drive(7'h04, '0, 1'b1, 1'b1, FA, 8'h04);
        expect_rd(FA, "R5 set beats bus clear");
        drive(7'h08, 7'h08, 1'b0, 1'b0, FA, '0);
        expect_rd(FA, "R5 set beats hw clear");

        // R12: unselected and unmapped writes
        drive('0, '0, 1'b0, 1'b1, FA, 8'h0C);
        expect_rd(FA, "R12 unselected write ignored");
        drive('0, '0, 1'b1, 1'b1, 4'd7, 8'hFF);
        expect_rd(FA, "R12 unmapped write flags");
        expect_rd(MA, "R12 unmapped write mask");
        expect_rd(4'd7, "R12 unmapped read zero");
        wr_reg(FA, 8'h7F);

        // R11: each source position
        wr_reg(MA, 8'hFF);
        for (int i = 0; i < 7; i++) begin
            drive(7'(1 << i), '0, 1'b0, 1'b0, FA, '0);
            expect_rd(FA, $sformatf("R11 source position %0d", i));
            wr_reg(FA, 8'(1 << i));
        end
        expect_rd(FA, "R11 all cleared");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule